// File: doc/BRIEF.md
# Ternary Longest-Prefix Route Lookup

This block resolves an IPv4 destination address to a next-hop index using a small ternary match table. Each entry stores a prefix value, a care mask and a next-hop index. The care mask is built from a prefix length, so every stored bit acts as 0, 1 or don't-care. Each clock cycle, the address on the lookup input is compared against every entry at once. The matching entry with the lowest index supplies the registered result one cycle later.

Software gives an entry the longest-prefix-match property by its position in the table. More specific routes go at lower indices. A /0 entry at the highest index then serves as a default route. Entries are installed or cleared through a single write port. A write takes effect from the cycle after it is presented, so a lookup in the same cycle still sees the old table.

Top module: `tcam_lpm`

## Requirements
- R1: An entry written with length L matches an address when the top L bits of the address equal the top L bits of the written prefix. Address bits and written prefix bits below the top L are ignored.
- R2: Length 0 matches every address. A length above 32 behaves as 32, which is an exact match.
- R3: After reset every entry is invalid, and the outputs read hit=0 and next_hop=0.
- R4: When several valid entries match, the one with the lowest index wins, whatever the prefix lengths are.
- R5: With longer prefixes written at lower indices, the result is the most specific route. For example, 128.9.16.14 resolves to 128.9.16.0/21 rather than 128.9.0.0/16.
- R6: When no valid entry matches, hit is 0 and next_hop is 0.
- R7: The result for the address sampled at a rising clock edge appears after that edge and holds until the next edge. Outputs are never unknown out of reset.
- R8: A write presented in the same cycle as a lookup does not affect that lookup. It affects the following one.
- R9: A write with wr_on=1 installs the entry as valid. A write with wr_on=0 makes that index invalid, and an invalid entry never matches.
- R10: While the address and the table are unchanged, hit and next_hop stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one table entry |
| wr_idx | input | IW (4) | Entry index; lower index has higher priority |
| wr_on | input | 1 | 1 installs a valid entry, 0 invalidates it |
| wr_prefix | input | AW (32) | Prefix value |
| wr_len | input | LW (6) | Prefix length; values above AW are clamped |
| wr_nh | input | NHW (8) | Next-hop index for the entry |
| lk_addr | input | AW (32) | Destination address to look up |
| hit | output | 1 | A valid entry matched the previous cycle's address |
| next_hop | output | NHW (8) | Next hop of the winning entry, or 0 on a miss |

## Verification
The assertions check three properties on every cycle:
- A miss always reports a zero next hop.
- A hit can only follow a cycle in which at least one entry was valid, as tracked from the write port.
- With a steady address and no writes, the outputs hold still, and they are never unknown.

Only the bench scenarios can show the points that depend on stored contents:
- which entry wins among overlapping prefixes, including priority by position over prefix length;
- masking of both address bits and written prefix bits below the prefix length;
- /0 and clamped lengths;
- invalidation;
- the old-table result of a lookup that coincides with a write.

// File: rtl/tcam_lpm.sv
module tcam_lpm #(
  parameter int ENTRIES = 16,
  parameter int AW = 32,
  parameter int NHW = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int LW = $clog2(AW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic           wr_on,
  input  logic [AW-1:0]  wr_prefix,
  input  logic [LW-1:0]  wr_len,
  input  logic [NHW-1:0] wr_nh,
  input  logic [AW-1:0]  lk_addr,
  output logic           hit,
  output logic [NHW-1:0] next_hop
);

  logic [AW-1:0]      ent_val [ENTRIES];
  logic [AW-1:0]      ent_msk [ENTRIES];
  logic [NHW-1:0]     ent_nh  [ENTRIES];
  logic [ENTRIES-1:0] ent_on;
  logic [ENTRIES-1:0] match;
  logic               sel_hit;
  logic [NHW-1:0]     sel_nh;

  wire [AW-1:0] wr_msk = (wr_len >= LW'(AW)) ? {AW{1'b1}} : ~({AW{1'b1}} >> wr_len);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_val[wr_idx] <= wr_prefix & wr_msk;
      ent_msk[wr_idx] <= wr_msk;
      ent_nh[wr_idx]  <= wr_nh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_on <= '0;
    else if (wr_en) ent_on[wr_idx] <= wr_on;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_on[g] && (((lk_addr ^ ent_val[g]) & ent_msk[g]) == '0);
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_nh  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_hit = 1'b1;
        sel_nh  = ent_nh[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      next_hop <= '0;
    end else begin
      hit      <= sel_hit;
      next_hop <= sel_nh;
    end
  end

endmodule

// File: rtl/tcam_lpm_chk.sv
module tcam_lpm_chk #(
  parameter int ENTRIES = 16,
  parameter int AW = 32,
  parameter int NHW = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [IW-1:0]  wr_idx,
  input logic           wr_on,
  input logic [AW-1:0]  lk_addr,
  input logic           hit,
  input logic [NHW-1:0] next_hop
);

  logic [ENTRIES-1:0] sh_on;
  logic [1:0]         warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_on <= '0;
      warm  <= '0;
    end else begin
      if (wr_en) sh_on[wr_idx] <= wr_on;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> next_hop == '0); // R6

  AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && hit) |-> $past(|sh_on)); // R9

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && $past(lk_addr) == $past(lk_addr, 2) && !$past(wr_en, 2))
      |-> ($stable(hit) && $stable(next_hop))); // R10

  AST_NO_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({hit, next_hop})); // R7

endmodule

bind tcam_lpm tcam_lpm_chk #(.ENTRIES(ENTRIES), .AW(AW), .NHW(NHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_on(wr_on),
  .lk_addr(lk_addr), .hit(hit), .next_hop(next_hop)
);

// File: tb/test_tcam_lpm.sv
module test_tcam_lpm;
  localparam int CLK_P = 10;
  localparam int NV = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic        wr_on = 1'b0;
  logic [31:0] wr_prefix = '0;
  logic [5:0]  wr_len = '0;
  logic [7:0]  wr_nh = '0;
  logic [31:0] lk_addr = '0;
  logic        hit;
  logic [7:0]  next_hop;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // {address, expected hit, expected next hop}
  localparam logic [40:0] VEC [NV] = '{
    {32'h8009100E, 1'b1, 8'd2},
    {32'h8009B005, 1'b1, 8'd1},
    {32'h800917FF, 1'b1, 8'd2},
    {32'h80091801, 1'b1, 8'd5},
    {32'h8009AA01, 1'b1, 8'd3},
    {32'h8009B100, 1'b1, 8'd5},
    {32'h8E0C1FFF, 1'b1, 8'd4},
    {32'h8E0C2000, 1'b0, 8'd0},
    {32'h41FF0001, 1'b1, 8'd6},
    {32'h42000000, 1'b0, 8'd0},
    {32'h00000000, 1'b0, 8'd0}
  };

  tcam_lpm i_tcam_lpm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_on(wr_on),
    .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_nh(wr_nh),
    .lk_addr(lk_addr), .hit(hit), .next_hop(next_hop)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(string req, logic g_hit, logic [7:0] g_nh, logic e_hit, logic [7:0] e_nh);
    n_chk++;
    if (g_hit !== e_hit || g_nh !== e_nh) begin
      n_bad++;
      $display("FAIL %s: got hit=%b nh=%0d, expected hit=%b nh=%0d", req, g_hit, g_nh, e_hit, e_nh);
    end
  endtask

  task automatic wr(int idx, logic [31:0] pfx, int len, int nh, logic on);
    wr_idx = 4'(idx); wr_prefix = pfx; wr_len = 6'(len); wr_nh = 8'(nh); wr_on = on;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(string req, logic [31:0] a, logic e_hit, logic [7:0] e_nh);
    lk_addr = a;
    @(posedge clk); #1;
    chk(req, hit, next_hop, e_hit, e_nh);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R3 reset outputs", hit, next_hop, 1'b0, 8'd0);
    look("R3 empty table", 32'h8009100E, 1'b0, 8'd0);

    wr(0, 32'h8009B000, 24, 1, 1'b1);
    wr(1, 32'h80091000, 21, 2, 1'b1);
    wr(2, 32'h8009AC00, 21, 3, 1'b1);  // R1: low prefix bits ignored
    wr(3, 32'h8E0C0000, 19, 4, 1'b1);
    wr(4, 32'h80090000, 16, 5, 1'b1);
    wr(5, 32'h41000000, 8, 6, 1'b1);

    for (int i = 0; i < NV; i++)
      look("R1/R5/R6 vector", VEC[i][40:9], VEC[i][8], VEC[i][7:0]);

    // R7: output unchanged before the edge, updated after it
    lk_addr = 32'h8009B005;
    @(posedge clk); #1;
    chk("R7 after edge", hit, next_hop, 1'b1, 8'd1);
    @(negedge clk);
    lk_addr = 32'h80091801;
    #1;
    chk("R7 before edge", hit, next_hop, 1'b1, 8'd1);
    @(posedge clk); #1;
    chk("R7 after next edge", hit, next_hop, 1'b1, 8'd5);
    @(negedge clk);

    wr(15, 32'hFFFFFFFF, 0, 9, 1'b1);
    look("R2 default route", 32'h42000000, 1'b1, 8'd9);
    look("R4 specific over default", 32'h8009100E, 1'b1, 8'd2);
    wr(7, 32'h0A000001, 40, 10, 1'b1);
    look("R2 clamped exact hit", 32'h0A000001, 1'b1, 8'd10);
    look("R2 clamped exact miss", 32'h0A000000, 1'b1, 8'd9);

    wr(9, 32'h41010203, 32, 11, 1'b1);
    look("R4 lower index wins over longer", 32'h41010203, 1'b1, 8'd6);
    wr(5, 32'h41000000, 8, 6, 1'b0);
    look("R9 invalidated entry skipped", 32'h41010203, 1'b1, 8'd11);

    // R8: clear entry 9 in the same cycle as a lookup that hits it
    wr_idx = 4'd9; wr_on = 1'b0; wr_len = 6'd32; wr_prefix = 32'h41010203; wr_nh = 8'd11;
    wr_en = 1'b1;
    lk_addr = 32'h41010203;
    @(posedge clk); #1;
    chk("R8 same-cycle sees old", hit, next_hop, 1'b1, 8'd11);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk); #1;
    chk("R8 next cycle sees new", hit, next_hop, 1'b1, 8'd9);
    @(negedge clk);

    wr(15, 32'h0, 0, 9, 1'b0);
    look("R9 default removed", 32'h42000000, 1'b0, 8'd0);
    @(posedge clk); #1;
    chk("R10 steady miss", hit, next_hop, 1'b0, 8'd0);
    @(negedge clk);

    rst_n = 1'b0;
    #1;
    chk("R3 async reset", hit, next_hop, 1'b0, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    look("R3 table cleared by reset", 32'h8009100E, 1'b0, 8'd0);

    summary();
  end
endmodule